// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This combinational unit shifts every lane of a 32-bit packed word by the same amount. The lanes are either four 8-bit lanes or two 16-bit lanes. Three shift kinds are supported: arithmetic right, logical right and logical left. The amount comes either from the low bits of a register operand or from an immediate field, and one select line chooses between them.

One bit of a 2-bit mode field changes what the shift does. With that bit set, a right shift rounds by adding back the last bit shifted out. With that bit set, a left shift saturates: any lane whose value would not survive the shift is clamped, and a single flag reports that a clamp happened. The decode stage upstream works out lane width and lane signedness from the register bank and presents them as two lines. Signedness only matters for saturating left shifts, because on right shifts the shift kind alone decides the fill bit.

The unit sits in the execute stage beside the packed adder. The result and the flag are valid in the same cycle as the inputs.

Top module: `pk_shift_unit`

## Requirements
- R1: With shift_kind 2'b00 and mode[0]=0, each lane is shifted right and filled with copies of its own sign bit. Bits shifted out are dropped.
- R2: With shift_kind 2'b01 and mode[0]=0, each lane is shifted right and filled with zeros.
- R3: With shift_kind[1]=1 (codes 2'b10 and 2'b11) and mode[0]=0, each lane is shifted left and filled with zeros. Bits moved above the lane are dropped, and sat_flag is 0.
- R4: With shift_kind[1]=0 and mode[0]=1, each lane's result is its truncated right shift plus the last bit shifted out. The sum is taken modulo the lane width.
- R5: With shift_kind[1]=1, mode[0]=1 and lane_signed=1, a lane whose value times 2^amount falls outside the signed lane range becomes the signed maximum (positive input) or the signed minimum (negative input). sat_flag is then 1.
- R6: With shift_kind[1]=1, mode[0]=1 and lane_signed=0, a lane whose unsigned value times 2^amount exceeds the lane maximum becomes all ones. sat_flag is then 1.
- R7: The amount is amt_imm when amt_use_imm=1 and amt_reg otherwise. 8-bit lanes use only bits [2:0] of the amount. 16-bit lanes use bits [3:0].
- R8: An effective amount of zero returns every lane unchanged, with no rounding increment and sat_flag 0.
- R9: With lane_wide=0, lane k is bits [8k+7:8k]. With lane_wide=1, lane k is bits [16k+15:16k]. No lane's result depends on another lane.
- R10: sat_flag is 1 exactly when a saturating left shift clamps at least one lane. It is 0 for every right shift.
- R11: mode[1] has no effect on the result or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 32 | Packed operand |
| amt_reg | input | 4 | Low bits of the register shift amount |
| amt_imm | input | 4 | Immediate shift amount |
| amt_use_imm | input | 1 | 1 selects the immediate amount |
| shift_kind | input | 2 | 00 arithmetic right, 01 logical right, 1x logical left |
| mode | input | 2 | Bit 0 enables rounding or saturation; bit 1 is ignored |
| lane_wide | input | 1 | 0 selects 8-bit lanes, 1 selects 16-bit lanes |
| lane_signed | input | 1 | Lane signedness for saturating left shifts |
| res_word | output | 32 | Packed result |
| sat_flag | output | 1 | At least one lane was clamped |

## Verification
The lane assertions assume that every input is driven to a known value, and they are skipped while any input is unknown. The bench drives all inputs from the first moment and never leaves one floating. The assertions also take lane_signed as a stable configuration line for the current operation. The random stimulus draws every field independently, so it reaches all four shift-kind codes, both values of each mode bit, both lane widths and amounts up to 15, including amounts with bits above the lane's amount range set. Directed vectors cover the clamp edges, values that only just fit, half-way rounding cases and zero amounts.

// File: rtl/pk_shift_pkg.sv
package pk_shift_pkg;

   typedef enum logic [1:0] {
      SHK_ARITH_R = 2'b00,
      SHK_LOGIC_R = 2'b01,
      SHK_LOGIC_L = 2'b10,
      SHK_LEFT_AL = 2'b11
   } shift_kind_e;

   function automatic logic kind_is_left(input logic [1:0] k);
      return k[1];
   endfunction

   function automatic logic kind_is_arith(input logic [1:0] k);
      return (k == SHK_ARITH_R);
   endfunction

endpackage

// File: rtl/pk_amt_pick.sv
module pk_amt_pick #(
   parameter int AW = 4
) (
   input  logic [AW-1:0] reg_amt,
   input  logic [AW-1:0] imm_amt,
   input  logic          use_imm,
   output logic [AW-1:0] amt
);
   assign amt = use_imm ? imm_amt : reg_amt;
endmodule

// File: rtl/pk_lane_shift.sv
module pk_lane_shift
   import pk_shift_pkg::*;
#(
   parameter int W = 8,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  x,
   input  logic [SW-1:0] sh,
   input  logic [1:0]    kind,
   input  logic          rnd_sat,
   input  logic          sgn,
   output logic [W-1:0]  y,
   output logic          sat
);
   logic          fill;
   logic [2*W-1:0] rext;
   logic [W:0]    rlo;
   logic [W-1:0]  trunc;
   logic [W-1:0]  rnd_y;
   logic [2*W-1:0] lext;
   logic          fits;
   logic [W-1:0]  clamp;

   // right path: a guard bit below the lane catches the last bit shifted out
   assign fill  = kind_is_arith(kind) & x[W-1];
   assign rext  = {{(W-1){fill}}, x, 1'b0};
   assign rlo   = (W+1)'(rext >> sh);
   assign trunc = rlo[W:1];
   assign rnd_y = trunc + {{(W-1){1'b0}}, rlo[0]};

   // left path: the upper half of a widened copy holds what would be lost
   assign lext = {{W{sgn & x[W-1]}}, x} << sh;

   always_comb begin
      if (sgn) begin
         fits  = (&lext[2*W-1:W-1]) | ~(|lext[2*W-1:W-1]);
         clamp = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end else begin
         fits  = ~(|lext[2*W-1:W]);
         clamp = {W{1'b1}};
      end
   end

   always_comb begin
      sat = 1'b0;
      if (kind_is_left(kind)) begin
         if (rnd_sat && !fits) begin
            y   = clamp;
            sat = 1'b1;
         end else begin
            y = lext[W-1:0];
         end
      end else begin
         y = rnd_sat ? rnd_y : trunc;
      end
   end

   always_comb begin
      if (!$isunknown({x, sh, kind, rnd_sat, sgn, y, sat})) begin
         // R8
         zero_amt_chk: assert (sh != '0 || (y == x && !sat));
         // R2
         srl_msb_chk: assert (!(kind == SHK_LOGIC_R && sh != '0 && !rnd_sat) || !y[W-1]);
         // R1
         sra_sign_chk: assert (!(kind == SHK_ARITH_R && !rnd_sat) || y[W-1] == x[W-1]);
         // R10
         sat_kind_chk: assert (!sat || (kind[1] && rnd_sat));
      end
   end
endmodule

// File: rtl/pk_lane_array.sv
module pk_lane_array #(
   parameter int WORD = 32,
   parameter int LW   = 8,
   localparam int NL  = WORD / LW,
   localparam int SW  = $clog2(LW)
) (
   input  logic [WORD-1:0] x,
   input  logic [SW-1:0]   sh,
   input  logic [1:0]      kind,
   input  logic            rnd_sat,
   input  logic            sgn,
   output logic [WORD-1:0] y,
   output logic            sat
);
   logic [NL-1:0] lane_sat;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      pk_lane_shift #(.W(LW)) u_lane (
         .x       (x[i*LW +: LW]),
         .sh      (sh),
         .kind    (kind),
         .rnd_sat (rnd_sat),
         .sgn     (sgn),
         .y       (y[i*LW +: LW]),
         .sat     (lane_sat[i])
      );
   end

   assign sat = |lane_sat;
endmodule

// File: rtl/pk_shift_unit.sv
module pk_shift_unit #(
   parameter int WORD   = 32,
   parameter int NARROW = 8,
   parameter int WIDE   = 16,
   localparam int AMT_W = $clog2(WIDE),
   localparam int NSW   = $clog2(NARROW)
) (
   input  logic [WORD-1:0]  src_word,
   input  logic [AMT_W-1:0] amt_reg,
   input  logic [AMT_W-1:0] amt_imm,
   input  logic             amt_use_imm,
   input  logic [1:0]       shift_kind,
   input  logic [1:0]       mode,
   input  logic             lane_wide,
   input  logic             lane_signed,
   output logic [WORD-1:0]  res_word,
   output logic             sat_flag
);
   if ((NARROW & (NARROW - 1)) != 0 || (WIDE & (WIDE - 1)) != 0) begin : g_bad_pow2
      $error("lane widths must be powers of two");
   end
   if (WIDE <= NARROW || WORD % WIDE != 0) begin : g_bad_fit
      $error("wide lane must exceed narrow lane and divide the word");
   end

   logic [AMT_W-1:0] amt;
   logic [WORD-1:0]  y_n, y_w;
   logic             s_n, s_w;
   logic             mode_unused;

   assign mode_unused = mode[1];

   pk_amt_pick #(.AW(AMT_W)) u_amt (
      .reg_amt (amt_reg),
      .imm_amt (amt_imm),
      .use_imm (amt_use_imm),
      .amt     (amt)
   );

   pk_lane_array #(.WORD(WORD), .LW(NARROW)) u_narrow (
      .x       (src_word),
      .sh      (amt[NSW-1:0]),
      .kind    (shift_kind),
      .rnd_sat (mode[0]),
      .sgn     (lane_signed),
      .y       (y_n),
      .sat     (s_n)
   );

   pk_lane_array #(.WORD(WORD), .LW(WIDE)) u_wide (
      .x       (src_word),
      .sh      (amt),
      .kind    (shift_kind),
      .rnd_sat (mode[0]),
      .sgn     (lane_signed),
      .y       (y_w),
      .sat     (s_w)
   );

   assign res_word = lane_wide ? y_w : y_n;
   assign sat_flag = lane_wide ? s_w : s_n;

   always_comb begin
      if (!$isunknown({shift_kind, mode, sat_flag})) begin
         // R3
         plain_noflag_chk: assert (mode[0] || !sat_flag);
         // R10
         right_noflag_chk: assert (shift_kind[1] || !sat_flag);
      end
   end
endmodule

// File: tb/test_pk_shift_unit.sv
`timescale 1ns/1ps
module test_pk_shift_unit;
   logic        clk = 1'b0;
   logic [31:0] src_word = '0;
   logic [3:0]  amt_reg = '0, amt_imm = '0;
   logic        amt_use_imm = 1'b0;
   logic [1:0]  shift_kind = '0, mode = '0;
   logic        lane_wide = 1'b0, lane_signed = 1'b0;
   logic [31:0] res_word;
   logic        sat_flag;
   int          n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   pk_shift_unit i_pk_shift_unit (
      .src_word(src_word), .amt_reg(amt_reg), .amt_imm(amt_imm),
      .amt_use_imm(amt_use_imm), .shift_kind(shift_kind), .mode(mode),
      .lane_wide(lane_wide), .lane_signed(lane_signed),
      .res_word(res_word), .sat_flag(sat_flag));

   task automatic ref_lane(input int w, input longint v, input int s, input bit [1:0] k,
                           input bit rs, input bit sg, output longint y, output bit f);
      longint mask, uv, sv, base, q, e, smax, smin;
      mask = (64'sd1 <<< w) - 1;
      uv   = v & mask;
      sv   = (uv >= (64'sd1 <<< (w-1))) ? uv - (64'sd1 <<< w) : uv;
      smax = (64'sd1 <<< (w-1)) - 1;
      smin = -(64'sd1 <<< (w-1));
      f = 1'b0;
      if (!k[1]) begin
         base = k[0] ? uv : sv;
         q = base >>> s;
         if (rs && s > 0) q = q + ((base >>> (s-1)) & 1);
         y = q & mask;
      end else begin
         e = (sg ? sv : uv) * (64'sd1 <<< s);
         y = e & mask;
         if (rs) begin
            if (sg && e > smax) begin y = smax; f = 1'b1; end
            else if (sg && e < smin) begin y = smin & mask; f = 1'b1; end
            else if (!sg && e > mask) begin y = mask; f = 1'b1; end
         end
      end
   endtask

   task automatic ref_word(output logic [31:0] y, output bit f);
      int w, s;
      longint ly;
      bit lf;
      w = lane_wide ? 16 : 8;
      s = int'(amt_use_imm ? amt_imm : amt_reg) & (w - 1);
      f = 1'b0;
      y = '0;
      for (int i = 0; i < 32 / w; i++) begin
         ref_lane(w, longint'((src_word >> (i*w)) & ((32'd1 << w) - 1)), s, shift_kind,
                  mode[0], lane_signed, ly, lf);
         y = y | (32'(ly) << (i*w));
         f = f | lf;
      end
   endtask

   task automatic apply(input logic [31:0] sw, input logic [3:0] ar, input logic [3:0] ai,
                        input logic ui, input logic [1:0] k, input logic [1:0] m,
                        input logic wd, input logic sg, input string tag);
      logic [31:0] ey;
      bit ef;
      @(negedge clk);
      src_word = sw; amt_reg = ar; amt_imm = ai; amt_use_imm = ui;
      shift_kind = k; mode = m; lane_wide = wd; lane_signed = sg;
      #1;
      ref_word(ey, ef);
      n_chk++;
      if (res_word !== ey || sat_flag !== ef) begin
         n_bad++;
         $display("FAIL %s: actual %h/%b expected %h/%b", tag, res_word, sat_flag, ey, ef);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      apply(32'h0, 4'h0, 4'h0, 0, 2'b00, 2'b00, 0, 0, "R1 idle zero");
      apply(32'h80F07F01, 4'h1, 4'h0, 0, 2'b00, 2'b00, 0, 0, "R1 sra byte");
      apply(32'h8001F00F, 4'h5, 4'h0, 0, 2'b00, 2'b00, 1, 1, "R1 sra half");
      apply(32'h80F07F01, 4'h1, 4'h0, 0, 2'b01, 2'b00, 0, 1, "R2 srl byte");
      apply(32'h81F0C00F, 4'h3, 4'h0, 0, 2'b10, 2'b00, 0, 1, "R3 sll byte");
      apply(32'h81F0C00F, 4'h7, 4'h0, 0, 2'b11, 2'b00, 1, 0, "R3 sll half alt code");
      apply(32'h0003FFFD, 4'h1, 4'h0, 0, 2'b00, 2'b01, 1, 1, "R4 round sra half");
      apply(32'hFF800301, 4'h1, 4'h0, 0, 2'b01, 2'b01, 0, 0, "R4 round srl byte");
      apply(32'h7F80C0FF, 4'h7, 4'h0, 0, 2'b00, 2'b01, 0, 1, "R4 round sra byte max amt");
      apply(32'h40C00181, 4'h1, 4'h0, 0, 2'b10, 2'b01, 0, 1, "R5 sat signed byte");
      apply(32'h4000C000, 4'h1, 4'h0, 0, 2'b10, 2'b01, 1, 1, "R5 sat signed half");
      apply(32'h2000E000, 4'h1, 4'h0, 0, 2'b10, 2'b01, 1, 1, "R5 just fits half");
      apply(32'h807F01FF, 4'h1, 4'h0, 0, 2'b10, 2'b01, 0, 0, "R6 sat unsigned byte");
      apply(32'h7FFF0001, 4'hF, 4'h0, 0, 2'b11, 2'b01, 1, 0, "R6 sat unsigned half");
      apply(32'h80F07F01, 4'h9, 4'h0, 0, 2'b00, 2'b00, 0, 0, "R7 amount low bits");
      apply(32'h80F07F01, 4'h7, 4'h2, 1, 2'b01, 2'b00, 0, 0, "R7 immediate select");
      apply(32'h80F07F01, 4'h2, 4'hC, 1, 2'b01, 2'b00, 1, 0, "R7 immediate half");
      apply(32'hC0017FFF, 4'h0, 4'h0, 0, 2'b10, 2'b01, 1, 1, "R8 zero amt sat left");
      apply(32'hFF0180FF, 4'h8, 4'h0, 0, 2'b00, 2'b01, 0, 1, "R8 zero amt round");
      apply(32'h00FF8001, 4'h4, 4'h0, 0, 2'b10, 2'b00, 0, 0, "R9 byte lanes");
      apply(32'h00FF8001, 4'h4, 4'h0, 0, 2'b10, 2'b00, 1, 0, "R9 half lanes");
      apply(32'h01010101, 4'h2, 4'h0, 0, 2'b10, 2'b01, 0, 1, "R10 no clamp no flag");
      apply(32'h80808080, 4'h3, 4'h0, 0, 2'b00, 2'b01, 0, 1, "R10 right no flag");
      apply(32'h40C00181, 4'h1, 4'h0, 0, 2'b10, 2'b10, 0, 1, "R11 mode bit1 plain");
      apply(32'h40C00181, 4'h1, 4'h0, 0, 2'b10, 2'b11, 0, 1, "R11 mode bit1 sat");
      for (int n = 0; n < 600; n++) begin
         apply($urandom(), 4'($urandom()), 4'($urandom()), 1'($urandom()), 2'($urandom()),
               2'($urandom()), 1'($urandom()), 1'($urandom()), "R9 random");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule